// File: doc/BRIEF.md
# Configurable I/O Port with Address-Lane Output Function

This block is an 8-bit bidirectional port. Each pin has its own direction bit. Each pin can work as a plain software-driven I/O. It can also carry one bit of an external address bus, taken from either the low address byte or the third address byte. A small synchronous register interface lets software program the output latch, the direction, the input gating and the two per-pin function selectors. The same interface reads back the gated pin state.

A bus-mode strap is sampled while reset is held, and the sampled value is kept until the next reset. With the strap high, the port runs in multiplexed mode and both address lanes are available to each pin. With the strap low, the port runs in separate mode and only the high lane can be used. All pin drive is removed during reset and while stop mode is active. A bus-release input removes drive only from the pins that carry the address function.

Register map (3-bit address): 0 = gated pin read (read-only), 1 = output latch, 2 = direction (1 = output), 3 = input enable, 4 = function select (1 = address), 5 = lane select (0 = low byte, 1 = high byte). Addresses 6 and 7 read as zero.

Top module: `addr_gpio_port`

## Requirements
- R1: While reset is low and after it is released, the output latch reads 8'hFF. The direction, input-enable, function-select and lane-select registers read 8'h00. All `pin_oe` bits are 0.
- R2: A write with `reg_wr_en` high updates the register at `reg_addr` on the next rising clock edge, and a read of that address returns the value written. A write to address 0 changes no register. Addresses 6 and 7 read 0.
- R3: A read of address 0 returns `pin_in` AND the input-enable register, so a pin whose enable bit is 0 reads as 0.
- R4: A pin whose function-select bit is 0 is enabled exactly when its direction bit is 1, and it then drives its output-latch bit.
- R5: In multiplexed mode (strap sampled high), a pin whose function-select bit is 1 drives `addr_lo` for its bit when its lane bit is 0 and `addr_hi` when its lane bit is 1. It is enabled whatever its direction bit holds.
- R6: In separate mode (strap sampled low), a pin whose function-select bit is 1 always drives `addr_hi`, and its lane bit has no effect.
- R7: While `bus_release` is 1, every pin whose function-select bit is 1 has `pin_oe` = 0. Pins in plain I/O function are not affected.
- R8: While `stop_mode` is 1 or reset is low, all `pin_oe` bits are 0. A pin whose `pin_oe` is 0 presents `pin_out` = 0.
- R9: The strap is sampled on each clock edge while reset is low. The last sample is held until the next reset, and changes to the strap after reset is released have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_mode_strap | input | 1 | Bus-mode strap, 1 = multiplexed, 0 = separate |
| stop_mode | input | 1 | Stop mode, removes all pin drive |
| bus_release | input | 1 | Removes drive from pins in the address function |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| addr_lo | input | 8 | Low address byte lane |
| addr_hi | input | 8 | High address byte lane |
| pin_in | input | 8 | Pad input values |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |

## Verification
The assertions assume that the strap is stable for at least one clock edge before reset is released, and that `reg_addr` and `reg_wdata` are stable while `reg_wr_en` is sampled. The bench holds the strap steady through every reset pulse. It changes the strap only after release, to show that the change is ignored. It drives every register and port input on the falling clock edge, so each write meets the next rising edge with settled values.

// File: rtl/agp_pkg.sv
package agp_pkg;
  localparam int AGP_AW = 3;

  typedef enum logic [AGP_AW-1:0] {
    RA_PIN   = 3'd0,
    RA_LATCH = 3'd1,
    RA_DIR   = 3'd2,
    RA_INEN  = 3'd3,
    RA_SEL   = 3'd4,
    RA_LANE  = 3'd5
  } reg_addr_e;

  // Which address lane a pin uses; separate mode forces the high lane.
  function automatic logic lane_is_high(input logic mux_mode, input logic lane_bit);
    return !mux_mode || lane_bit;
  endfunction

  // Value a pin presents when it is driven.
  function automatic logic pick_bit(input logic sel, input logic hi_lane,
                                    input logic lo_v, input logic hi_v,
                                    input logic latch_v);
    if (!sel) return latch_v;
    return hi_lane ? hi_v : lo_v;
  endfunction

  // Output enable of one pin.
  function automatic logic pin_drive(input logic kill, input logic sel,
                                     input logic released, input logic dir);
    if (kill) return 1'b0;
    return sel ? !released : dir;
  endfunction
endpackage

// File: rtl/agp_regs.sv
module agp_regs
  import agp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AGP_AW-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      rdata,
  output logic [W-1:0]      latch_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      inen_q,
  output logic [W-1:0]      sel_q,
  output logic [W-1:0]      lane_q
);
  logic wr_latch, wr_dir, wr_inen, wr_sel, wr_lane;

  assign wr_latch = wr_en && (addr == RA_LATCH);
  assign wr_dir   = wr_en && (addr == RA_DIR);
  assign wr_inen  = wr_en && (addr == RA_INEN);
  assign wr_sel   = wr_en && (addr == RA_SEL);
  assign wr_lane  = wr_en && (addr == RA_LANE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '1;
    else if (wr_latch) latch_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= '0;
    else if (wr_dir) dir_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inen_q <= '0;
    else if (wr_inen) inen_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else if (wr_sel) sel_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lane_q <= '0;
    else if (wr_lane) lane_q <= wdata;
  end

  always_comb begin
    case (addr)
      RA_PIN:   rdata = pin_in & inen_q;
      RA_LATCH: rdata = latch_q;
      RA_DIR:   rdata = dir_q;
      RA_INEN:  rdata = inen_q;
      RA_SEL:   rdata = sel_q;
      RA_LANE:  rdata = lane_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/agp_strap.sv
module agp_strap (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_in,
  output logic mode_q
);
  // Sampled on every edge while reset is held; frozen once released.
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= strap_in;
  end
endmodule

// File: rtl/agp_pin_mux.sv
module agp_pin_mux
  import agp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         kill,
  input  logic         released,
  input  logic         mux_mode,
  input  logic [W-1:0] sel,
  input  logic [W-1:0] lane,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] latch,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic [W-1:0] out,
  output logic [W-1:0] oe
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic hi_lane, val;
    assign hi_lane = lane_is_high(mux_mode, lane[b]);
    assign val     = pick_bit(sel[b], hi_lane, lo[b], hi[b], latch[b]);
    assign oe[b]   = pin_drive(kill, sel[b], released, dir[b]);
    assign out[b]  = oe[b] & val;
  end
endmodule

// File: rtl/addr_gpio_port.sv
module addr_gpio_port
  import agp_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_mode_strap,
  input  logic              stop_mode,
  input  logic              bus_release,
  input  logic              reg_wr_en,
  input  logic [AGP_AW-1:0] reg_addr,
  input  logic [PORT_W-1:0] reg_wdata,
  output logic [PORT_W-1:0] reg_rdata,
  input  logic [PORT_W-1:0] addr_lo,
  input  logic [PORT_W-1:0] addr_hi,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe
);
  logic [PORT_W-1:0] latch_q, dir_q, inen_q, sel_q, lane_q;
  logic              mux_mode_q;
  logic              drive_kill;

  assign drive_kill = !rst_n || stop_mode;

  agp_regs #(.W(PORT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .pin_in(pin_in), .rdata(reg_rdata),
    .latch_q(latch_q), .dir_q(dir_q), .inen_q(inen_q),
    .sel_q(sel_q), .lane_q(lane_q)
  );

  agp_strap u_strap (
    .clk(clk), .rst_n(rst_n), .strap_in(bus_mode_strap), .mode_q(mux_mode_q)
  );

  agp_pin_mux #(.W(PORT_W)) u_mux (
    .kill(drive_kill), .released(bus_release), .mux_mode(mux_mode_q),
    .sel(sel_q), .lane(lane_q), .dir(dir_q), .latch(latch_q),
    .lo(addr_lo), .hi(addr_hi), .out(pin_out), .oe(pin_oe)
  );
endmodule

// File: rtl/agp_checker.sv
module agp_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         stop_mode,
  input logic         bus_release,
  input logic [2:0]   reg_addr,
  input logic [W-1:0] reg_rdata,
  input logic [W-1:0] pin_in,
  input logic [W-1:0] addr_hi,
  input logic [W-1:0] pin_out,
  input logic [W-1:0] pin_oe,
  input logic [W-1:0] sel_q,
  input logic [W-1:0] dir_q,
  input logic [W-1:0] inen_q,
  input logic         mux_mode_q
);
  always_comb begin
    if (!rst_n || stop_mode) p_kill_oe_r8: assert (pin_oe == '0);
  end

  p_undriven_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);

  p_gpio_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_mode |-> ((pin_oe & ~sel_q) == (dir_q & ~sel_q)));

  p_addr_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_mode && !bus_release) |-> ((pin_oe & sel_q) == sel_q));

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_release |-> ((pin_oe & sel_q) == '0));

  p_sep_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mux_mode_q |-> ((pin_out & sel_q & pin_oe) == (addr_hi & sel_q & pin_oe)));

  p_pin_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd0) |-> (reg_rdata == (pin_in & inen_q)));

  p_strap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mux_mode_q));
endmodule

bind addr_gpio_port agp_checker #(.W(PORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_mode(stop_mode), .bus_release(bus_release),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .pin_in(pin_in),
  .addr_hi(addr_hi), .pin_out(pin_out), .pin_oe(pin_oe), .sel_q(sel_q),
  .dir_q(dir_q), .inen_q(inen_q), .mux_mode_q(mux_mode_q)
);

// File: tb/addr_gpio_port_bench.sv
module addr_gpio_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap = 1'b1, stop = 1'b0, rel = 1'b0, wr = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00, lo = 8'h00, hi = 8'h00, pin_in = 8'h00;
  logic [7:0] rdata, pout, poe;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  addr_gpio_port u_addr_gpio_port (
    .clk(clk), .rst_n(rst_n), .bus_mode_strap(strap), .stop_mode(stop),
    .bus_release(rel), .reg_wr_en(wr), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .addr_lo(lo), .addr_hi(hi), .pin_in(pin_in),
    .pin_out(pout), .pin_oe(poe)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk); strap = s; rst_n = 1'b0;
    #1; check("R8 oe in reset", poe, 8'h00);
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  // Expected pin behaviour, computed bit by bit from the requirements.
  function automatic void model(input logic mm, input logic [7:0] s, ln, d, lt,
                                input logic [7:0] l, h, input logic kil, rl,
                                output logic [7:0] eo, ev);
    for (int b = 0; b < 8; b++) begin
      logic drv, v;
      if (kil) drv = 1'b0;
      else if (s[b]) drv = ~rl;
      else drv = d[b];
      if (!s[b]) v = lt[b];
      else if (mm && !ln[b]) v = l[b];
      else v = h[b];
      eo[b] = drv;
      ev[b] = drv ? v : 1'b0;
    end
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, eo, ev, s, ln, d, lt;
    for (int m = 1; m >= 0; m--) begin
      do_reset(m[0]);
      // R1 reset values
      rd_reg(3'd1, r); check("R1 latch", r, 8'hFF);
      rd_reg(3'd2, r); check("R1 dir", r, 8'h00);
      rd_reg(3'd3, r); check("R1 inen", r, 8'h00);
      rd_reg(3'd4, r); check("R1 sel", r, 8'h00);
      rd_reg(3'd5, r); check("R1 lane", r, 8'h00);
      check("R1 oe", poe, 8'h00);
      // R3 gated pin read
      pin_in = 8'hA5; rd_reg(3'd0, r); check("R3 disabled read", r, 8'h00);
      wr_reg(3'd3, 8'h5A);
      for (int k = 0; k < 32; k++) begin
        pin_in = 8'(k * 53 + 7); rd_reg(3'd0, r);
        check("R3 gated read", r, pin_in & 8'h5A);
      end
      // R2 write to address 0 ignored; unmapped reads zero
      wr_reg(3'd0, 8'h3C);
      rd_reg(3'd1, r); check("R2 latch after addr0 write", r, 8'hFF);
      rd_reg(3'd2, r); check("R2 dir after addr0 write", r, 8'h00);
      rd_reg(3'd6, r); check("R2 addr6", r, 8'h00);
      rd_reg(3'd7, r); check("R2 addr7", r, 8'h00);
      // Sweep of function/lane/direction/latch patterns
      for (int k = 0; k < 256; k++) begin
        s = 8'(k); ln = 8'(k * 29) ^ 8'hC3; d = ~8'(k ^ (k << 1)); lt = 8'(k * 7);
        wr_reg(3'd4, s); wr_reg(3'd5, ln); wr_reg(3'd2, d); wr_reg(3'd1, lt);
        @(negedge clk);
        lo = 8'(k * 11 + 3); hi = ~8'(k * 5); rel = k[1]; stop = (k % 7 == 0);
        #1;
        model(m[0], s, ln, d, lt, lo, hi, stop, rel, eo, ev);
        if (stop) begin
          check("R8 stop oe", poe, 8'h00);
          check("R8 stop out", pout, 8'h00);
        end else begin
          check("R4 gpio oe", poe & ~s, eo & ~s);
          check("R4 gpio out", pout & ~s, ev & ~s);
          if (rel) check("R7 release oe", poe, eo);
          else if (m == 1) check("R5 mux lane out", pout & s, ev & s);
          else check("R6 separate lane out", pout & s, ev & s);
        end
        if (k % 16 == 5) begin
          rd_reg(3'd5, r); check("R2 lane readback", r, ln);
          rd_reg(3'd1, r); check("R2 latch readback", r, lt);
        end
        rel = 1'b0; stop = 1'b0;
      end
      // R9 strap change after reset has no effect
      strap = ~m[0];
      wr_reg(3'd4, 8'hFF); wr_reg(3'd5, 8'h00);
      @(negedge clk); lo = 8'hAA; hi = 8'h55; #1;
      check("R9 strap held", pout, (m == 1) ? 8'hAA : 8'h55);
      check("R5 address oe ignores dir", poe, 8'hFF);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule